// File: doc/BRIEF.md
# Overlapped Translation and Cache Read Unit

This block serves CPU loads from a 4 KB direct-mapped data store and translates the address in the same lookup cycle. The line index is taken from address bits that sit inside the 4 KB page displacement, so the store can be read before translation completes. At the same time an 8-entry fully associative translation buffer matches the upper 20 virtual address bits. A load completes from the store only when the translation buffer hits, the selected line is valid and its 20-bit stored tag equals the translated physical page.

A load that translates but misses in the store, or finds a different tag there, fetches one 32-bit word from memory at the physical address. The word is written into the line and handed to the CPU in the same cycle. A load whose page is not in the buffer raises a translation request. It waits until an entry is written through the refill port and then repeats the lookup. Each entry holds the virtual page, physical page, dirty flag, access flags, a referenced flag and a valid flag.

Every data stream uses valid/ready. A producer holds valid and its payload stable until it sees ready, and a transfer happens on any clock edge where both are high. The CPU response, the translation request and the memory request all obey this. The memory response is accepted only while the CPU takes the forwarded word in the same cycle, so CPU back-pressure passes straight through to memory. Only one load is in flight at a time. The refill port is a plain write strobe and is taken on every cycle it is raised.

Top module: `vipt_dcache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `xlat_req_valid` and `mem_req_valid` are 0. Every line and every translation entry is invalid, so the first load to any address raises one translation request and one memory read.
- R2: The line index is virtual address bits [11:2], and bits [1:0] do not affect the lookup. The tag compare uses the translated physical page. Two virtual pages that map to the same physical page therefore share lines.
- R3: On a hit (translation hit, line valid, stored tag equal to the physical page), `rsp_valid` rises in the cycle after the lookup cycle, that is one cycle after the request is accepted plus one. The response carries the stored word, and no memory or translation request is raised.
- R4: On a translation hit with an invalid line or a tag mismatch, exactly one memory request is issued at address {physical page, vaddr[11:2], 2'b00}.
- R5: While waiting for the fill, `rsp_valid` follows `mem_rsp_valid`, `rsp_data` equals `mem_rsp_data`, and `mem_rsp_ready` follows `rsp_ready`. On that transfer the line is written with the word, the physical page tag and valid, so a later load hits.
- R6: On a translation miss, `xlat_req_vpn` carries vaddr[31:12]. Once the request is taken, the block waits for a refill and then repeats the lookup.
- R7: A refill whose virtual page is already present overwrites that entry. Otherwise it fills the lowest-numbered invalid entry. If all entries are valid it replaces the entry at a round-robin pointer, which starts at entry 0 after reset and advances by one for each such replacement.
- R8: A translation hit sets the entry's referenced flag, and a refill clears it. `rsp_seen` returns the flag as it was before the current lookup.
- R9: `rsp_dirty` and `rsp_acc` return the dirty and access flags of the entry that translated the load.
- R10: `xlat_req_valid`, `mem_req_valid` and a hit response each stay high with a stable payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU load request valid |
| req_ready | output | 1 | Block can accept a load |
| req_vaddr | input | 32 | Virtual byte address |
| rsp_valid | output | 1 | Load data valid |
| rsp_ready | input | 1 | CPU accepts load data |
| rsp_data | output | 32 | Load data word |
| rsp_dirty | output | 1 | Dirty flag of translating entry |
| rsp_acc | output | 2 | Access flags of translating entry |
| rsp_seen | output | 1 | Referenced flag before this lookup |
| xlat_req_valid | output | 1 | Translation request valid |
| xlat_req_ready | input | 1 | Translation unit takes the request |
| xlat_req_vpn | output | 20 | Virtual page to translate |
| refill_valid | input | 1 | Write one translation entry |
| refill_vpn | input | 20 | Virtual page of new entry |
| refill_ppn | input | 20 | Physical page of new entry |
| refill_dirty | input | 1 | Dirty flag of new entry |
| refill_acc | input | 2 | Access flags of new entry |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Physical word address of the fill |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Block takes memory data |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The assertions check several rules on every cycle. Translation entries never match the same page twice. A hit sets the referenced flag. A filled line reads back valid with its new tag. The three outbound streams hold their payload while stalled. Only the bench's scenarios can show the rest: that hits avoid memory and translation traffic and answer with the right latency, that fills use the translated address, and that physically tagged lines are shared between aliased pages. The bench also confirms the replacement order of refills and that a second reset forgets every line and entry.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned VA_W_D       = 32;
  localparam int unsigned PG_OFF_W_D   = 12;
  localparam int unsigned BYTE_OFF_W_D = 2;
  localparam int unsigned TLB_N_D      = 8;
  localparam int unsigned ACC_W_D      = 2;
  localparam int unsigned DATA_W_D     = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_XREQ, ST_WALK, ST_MREQ, ST_MWAIT, ST_RESP
  } lu_state_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned ACC_W = 2,
  parameter int unsigned N     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  output logic [ACC_W-1:0] lk_acc,
  output logic             lk_ref,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic [ACC_W-1:0] fill_acc
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld, refd, dty, match, fmatch;
  logic [VPN_W-1:0] vpn_t [N];
  logic [PPN_W-1:0] ppn_t [N];
  logic [ACC_W-1:0] acc_t [N];
  logic [IW-1:0]    rr_q, hit_idx, vict;
  logic             use_rr;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g]  = vld[g] && (vpn_t[g] == lk_vpn);
      assign fmatch[g] = vld[g] && (vpn_t[g] == fill_vpn);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) if (match[i]) hit_idx = IW'(i);
  end

  // victim: existing page first, then lowest free slot, then rotating pointer
  always_comb begin
    vict   = rr_q;
    use_rr = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin vict = IW'(i); use_rr = 1'b0; end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (fmatch[i]) begin vict = IW'(i); use_rr = 1'b0; end
    end
  end

  assign lk_hit   = |match;
  assign lk_ppn   = ppn_t[hit_idx];
  assign lk_dirty = dty[hit_idx];
  assign lk_acc   = acc_t[hit_idx];
  assign lk_ref   = refd[hit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      refd <= '0;
      rr_q <= '0;
    end else begin
      if (lk_en && lk_hit) refd[hit_idx] <= 1'b1;
      if (fill_en) begin
        vld[vict]  <= 1'b1;
        refd[vict] <= 1'b0;
        if (use_rr) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_t[vict] <= fill_vpn;
      ppn_t[vict] <= fill_ppn;
      acc_t[vict] <= fill_acc;
      dty[vict]   <= fill_dirty;
    end
  end

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_ref_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && !fill_en) |=> refd[$past(hit_idx)]);
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assert_fill_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_idx != $past(wr_idx)) || (rd_valid && rd_tag == $past(wr_tag))));
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W       = VA_W_D,
  parameter int unsigned PG_OFF_W   = PG_OFF_W_D,
  parameter int unsigned BYTE_OFF_W = BYTE_OFF_W_D,
  parameter int unsigned TLB_N      = TLB_N_D,
  parameter int unsigned ACC_W      = ACC_W_D,
  parameter int unsigned DATA_W     = DATA_W_D,
  localparam int unsigned VPN_W     = VA_W - PG_OFF_W,
  localparam int unsigned IDX_W     = PG_OFF_W - BYTE_OFF_W,
  localparam int unsigned PA_W      = VPN_W + PG_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic [ACC_W-1:0]  rsp_acc,
  output logic              rsp_seen,
  output logic              xlat_req_valid,
  input  logic              xlat_req_ready,
  output logic [VPN_W-1:0]  xlat_req_vpn,
  input  logic              refill_valid,
  input  logic [VPN_W-1:0]  refill_vpn,
  input  logic [VPN_W-1:0]  refill_ppn,
  input  logic              refill_dirty,
  input  logic [ACC_W-1:0]  refill_acc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  lu_state_e         st_q;
  logic [VPN_W-1:0]  vpn_q, ppn_q;
  logic [IDX_W-1:0]  idx_q;
  logic              dirty_q, seen_q;
  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] data_q;

  logic              lk_hit, lk_dirty, lk_ref;
  logic [VPN_W-1:0]  lk_ppn;
  logic [ACC_W-1:0]  lk_acc;
  logic              c_valid, line_hit, fill_fire;
  logic [VPN_W-1:0]  c_tag;
  logic [DATA_W-1:0] c_data;
  logic              unused_boff;

  assign unused_boff = ^req_vaddr[BYTE_OFF_W-1:0];

  // page number goes to the associative match while the displacement bits
  // address the line store in the same cycle
  vipt_tlb #(.VPN_W(VPN_W), .PPN_W(VPN_W), .ACC_W(ACC_W), .N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_en(st_q == ST_LOOK), .lk_vpn(vpn_q),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty), .lk_acc(lk_acc), .lk_ref(lk_ref),
    .fill_en(refill_valid), .fill_vpn(refill_vpn), .fill_ppn(refill_ppn),
    .fill_dirty(refill_dirty), .fill_acc(refill_acc)
  );

  vipt_line_store #(.IDX_W(IDX_W), .TAG_W(VPN_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx_q), .rd_valid(c_valid), .rd_tag(c_tag), .rd_data(c_data),
    .wr_en(fill_fire), .wr_idx(idx_q), .wr_tag(ppn_q), .wr_data(mem_rsp_data)
  );

  assign line_hit       = lk_hit && c_valid && (c_tag == lk_ppn);
  assign fill_fire      = (st_q == ST_MWAIT) && mem_rsp_valid && rsp_ready;

  assign req_ready      = (st_q == ST_IDLE);
  assign xlat_req_valid = (st_q == ST_XREQ);
  assign xlat_req_vpn   = vpn_q;
  assign mem_req_valid  = (st_q == ST_MREQ);
  assign mem_req_addr   = {ppn_q, idx_q, {BYTE_OFF_W{1'b0}}};
  assign mem_rsp_ready  = (st_q == ST_MWAIT) && rsp_ready;
  assign rsp_valid      = (st_q == ST_RESP) || ((st_q == ST_MWAIT) && mem_rsp_valid);
  assign rsp_data       = (st_q == ST_MWAIT) ? mem_rsp_data : data_q;
  assign rsp_dirty      = dirty_q;
  assign rsp_acc        = acc_q;
  assign rsp_seen       = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      vpn_q   <= '0;
      idx_q   <= '0;
      ppn_q   <= '0;
      dirty_q <= 1'b0;
      acc_q   <= '0;
      seen_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          vpn_q <= req_vaddr[VA_W-1:PG_OFF_W];
          idx_q <= req_vaddr[PG_OFF_W-1:BYTE_OFF_W];
          st_q  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!lk_hit) st_q <= ST_XREQ;
          else begin
            ppn_q   <= lk_ppn;
            dirty_q <= lk_dirty;
            acc_q   <= lk_acc;
            seen_q  <= lk_ref;
            data_q  <= c_data;
            st_q    <= line_hit ? ST_RESP : ST_MREQ;
          end
        end
        ST_XREQ:  if (xlat_req_ready) st_q <= ST_WALK;
        ST_WALK:  if (refill_valid) st_q <= ST_LOOK;
        ST_MREQ:  if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid && rsp_ready) st_q <= ST_IDLE;
        ST_RESP:  if (rsp_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assert_xlat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req_valid && !xlat_req_ready) |=> (xlat_req_valid && $stable(xlat_req_vpn)));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RESP) && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/vipt_dcache_tb.sv
module vipt_dcache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_data;
  logic        rsp_dirty, rsp_seen;
  logic [1:0]  rsp_acc;
  logic        xlat_req_valid, xlat_req_ready;
  logic [19:0] xlat_req_vpn;
  logic        refill_valid, refill_dirty;
  logic [19:0] refill_vpn, refill_ppn;
  logic [1:0]  refill_acc;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vipt_dcache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_dirty(rsp_dirty), .rsp_acc(rsp_acc), .rsp_seen(rsp_seen),
    .xlat_req_valid(xlat_req_valid), .xlat_req_ready(xlat_req_ready), .xlat_req_vpn(xlat_req_vpn),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_dirty(refill_dirty), .refill_acc(refill_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad   = 0;

  // bench-side models built from the requirements
  bit          mv [8];
  logic [19:0] mvpn [8];
  logic [19:0] mppn [8];
  bit          mdty [8];
  logic [1:0]  macc [8];
  bit          mref [8];
  int          mrr;
  bit          cv [1024];
  logic [19:0] ct [1024];
  bit          remap_on;
  logic [19:0] remap_vpn, remap_ppn;
  int          last_nx, last_nm;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [19:0] pt_ppn(input logic [19:0] v);
    return v * 20'd37 + 20'h1B3;
  endfunction
  function automatic logic [19:0] src_ppn(input logic [19:0] v);
    return (remap_on && v == remap_vpn) ? remap_ppn : pt_ppn(v);
  endfunction
  function automatic logic [31:0] memword(input logic [31:0] pa);
    return (pa * 32'h9E3779B1) ^ 32'h5BD1E995;
  endfunction
  function automatic int model_find(input logic [19:0] v);
    int s = -1;
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == v) s = i;
    return s;
  endfunction

  task automatic model_refill(input logic [19:0] v, input logic [19:0] p);
    int s = model_find(v);
    if (s < 0) for (int i = 7; i >= 0; i--) if (!mv[i]) s = i;
    if (s < 0) begin s = mrr; mrr = (mrr + 1) % 8; end
    mv[s] = 1'b1; mvpn[s] = v; mppn[s] = p;
    mdty[s] = ^v; macc[s] = v[3:2]; mref[s] = 1'b0;
  endtask

  task automatic drive_refill(input logic [19:0] v, input logic [19:0] p);
    refill_valid = 1'b1; refill_vpn = v; refill_ppn = p;
    refill_dirty = ^v; refill_acc = v[3:2];
    @(negedge clk);
    refill_valid = 1'b0;
    model_refill(v, p);
  endtask

  task automatic idle_wait(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; rsp_ready = 0; xlat_req_ready = 0;
    refill_valid = 0; refill_vpn = '0; refill_ppn = '0; refill_dirty = 0; refill_acc = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mref[i] = 0; end
    for (int i = 0; i < 1024; i++) cv[i] = 0;
    mrr = 0;
    idle_wait(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] va);
    logic [19:0] v  = va[31:12];
    logic [9:0]  ix = va[11:2];
    int  pre = model_find(v);
    bit  ex  = (pre < 0);
    bit  pre_ref = (pre >= 0) ? mref[pre] : 1'b0;
    int  nx = 0, nm = 0, polls = 0, first_rsp = 0, post;
    bit  done = 0, efill;
    logic [31:0] got = '0, maddr = '0, epa;
    logic [19:0] eppn;
    logic        gdty = 0, gseen = 0;
    logic [1:0]  gacc = '0;

    req_valid = 1'b1; req_vaddr = va; rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && polls < 200) begin
      @(negedge clk);
      polls++;
      if (rsp_valid) begin
        if (first_rsp == 0) first_rsp = polls;
        if ($urandom % 3 != 0) begin
          got = rsp_data; gdty = rsp_dirty; gacc = rsp_acc; gseen = rsp_seen;
          rsp_ready = 1'b1;
          @(negedge clk);
          rsp_ready = 1'b0; mem_rsp_valid = 1'b0;
          done = 1;
        end
      end else if (xlat_req_valid) begin
        nx++;
        check(xlat_req_vpn == v, "R6 miss page", {12'h0, xlat_req_vpn}, {12'h0, v});
        idle_wait($urandom % 3);
        xlat_req_ready = 1'b1;
        @(negedge clk);
        xlat_req_ready = 1'b0;
        idle_wait($urandom % 3);
        drive_refill(v, src_ppn(v));
      end else if (mem_req_valid) begin
        nm++;
        maddr = mem_req_addr;
        idle_wait($urandom % 3);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        idle_wait($urandom % 3);
        mem_rsp_valid = 1'b1; mem_rsp_data = memword(maddr);
      end
    end
    check(done, "R10 response seen", {31'h0, done}, 32'h1);
    post = model_find(v);
    check(post >= 0, "R6 entry present", post, 0);
    if (post < 0) post = 0;
    eppn  = mppn[post];
    epa   = {eppn, ix, 2'b00};
    efill = !(cv[ix] && ct[ix] == eppn);
    check(nx == int'(ex), "R6 translation requests", nx, int'(ex));
    check(nm == int'(efill), "R4 memory requests", nm, int'(efill));
    if (efill && nm == 1) check(maddr == epa, "R4 fill address", maddr, epa);
    check(got == memword(epa), efill ? "R5 fill data" : "R3 hit data", got, memword(epa));
    check({gdty, gacc} == {mdty[post], macc[post]}, "R9 entry flags",
          {29'h0, gdty, gacc}, {29'h0, mdty[post], macc[post]});
    check(gseen == (ex ? 1'b0 : pre_ref), "R8 referenced flag", {31'h0, gseen}, {31'h0, ex ? 1'b0 : pre_ref});
    if (!ex && !efill) check(first_rsp == 1, "R3 hit latency", first_rsp, 1);
    mref[post] = 1'b1;
    if (efill) begin cv[ix] = 1'b1; ct[ix] = eppn; end
    last_nx = nx; last_nm = nm;
  endtask

  task automatic run_all();
    logic [19:0] vpool [12];
    logic [9:0]  ipool [6];
    logic [31:0] last_va = 32'h0;
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    remap_on = 0;

    do_reset();
    check(req_ready && !rsp_valid && !xlat_req_valid && !mem_req_valid, "R1 reset outputs",
          {28'h0, req_ready, rsp_valid, xlat_req_valid, mem_req_valid}, 32'h8);
    do_read(32'h1234_5678);
    check(last_nx == 1 && last_nm == 1, "R1 cold miss", last_nx * 16 + last_nm, 32'h11);
    do_read(32'h1234_5678);
    do_read(32'h1234_567B);
    check(last_nm == 0 && last_nx == 0, "R2 byte offset ignored", last_nm + last_nx, 0);
    // alias: second page maps to the same physical page
    drive_refill(20'hABCDE, pt_ppn(20'h12345));
    do_read(32'hABCD_E678);
    check(last_nm == 0 && last_nx == 0, "R2 physical tag shared", last_nm + last_nx, 0);
    do_read(32'h7777_7678);
    do_read(32'h1234_5678);
    check(last_nm == 1, "R2 index conflict refetch", last_nm, 1);

    // replacement order
    do_reset();
    for (int i = 0; i < 9; i++) drive_refill(20'h00100 + 20'(i), pt_ppn(20'h00100 + 20'(i)));
    do_read(32'h0010_1010);
    check(last_nx == 0, "R7 survivor kept", last_nx, 0);
    do_read(32'h0010_0010);
    check(last_nx == 1, "R7 first entry replaced", last_nx, 1);
    do_read(32'h0010_1010);
    check(last_nx == 1, "R7 pointer advanced", last_nx, 1);
    remap_on = 1; remap_vpn = 20'h00103; remap_ppn = 20'hF0F0F;
    drive_refill(20'h00103, 20'hF0F0F);
    do_read(32'h0010_3020);
    check(last_nx == 0 && last_nm == 1, "R7 overwrite in place", last_nx * 16 + last_nm, 32'h1);
    remap_on = 0;

    // constrained random traffic
    for (int i = 0; i < 12; i++) vpool[i] = 20'($urandom);
    for (int i = 0; i < 6; i++) ipool[i] = 10'($urandom);
    for (int n = 0; n < 250; n++) begin
      last_va = {vpool[$urandom % 12], ipool[$urandom % 6], 2'($urandom)};
      do_read(last_va);
    end

    do_reset();
    do_read(last_va);
    check(last_nx == 1 && last_nm == 1, "R1 reset forgets contents", last_nx * 16 + last_nm, 32'h11);
  endtask

  initial begin
    bit timeout = 0;
    fork
      run_all();
      begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=%0d expected=0", WATCHDOG);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule